// File: doc/BRIEF.md
# Latched Buck Protection Supervisor

This block is the digital protection supervisor of a single-phase synchronous step-down regulator. Analog comparators outside the block watch the output and the inductor current. They hand it four one-bit flags: output over the upper limit, output under the lower limit, output below half the reference, and inductor current over its limit. The block resamples each flag on the switching clock through a two-flop synchronizer. From them it derives overrides for the gate-drive stage: force the low-side switch on, turn both switches off, and blank the PWM so the high side stays off. It also drives the power-good output and a request that restarts soft-start.

An overvoltage latches a fault and clamps the output through the low-side switch. The clamp releases once the output falls below half the reference, and it comes back whenever the overvoltage flag returns. An undervoltage outside soft-start latches a fault and opens both switches. During soft-start, an undervoltage instead asks the sequencer to start the ramp again, which lets the regulator detect a missing input supply. An overcurrent terminates the switching cycle and holds the low side on. Seven overcurrent cycles in a row latch a fault with both switches off. While the converter is disabled, an overvoltage turns on a low-side clamp that is held until enable goes high. Every latched fault clears only when enable is sampled low or the block is reset.

Top module: `buck_prot_sup`

## Requirements
- R1: Each comparator flag passes through two synchronizer flops. A flag driven before rising edge 1 can change an output no earlier than rising edge 3.
- R2: While enabled, a synchronized overvoltage latches the overvoltage fault and asserts `ls_force` at the next edge. `ls_force` stays on until a cycle with the synchronized half-reference flag high and the overvoltage flag low. While the fault is latched, any new overvoltage asserts `ls_force` again.
- R3: `pwm_blank` is 1 whenever enable (registered) is low, any fault latch is set, the pre-enable clamp is set, or the previous cycle saw a synchronized overcurrent.
- R4: While enabled, with `uv_armed`=1 and `ss_active`=0, a synchronized undervoltage latches the undervoltage fault. `all_off` is 1 while an undervoltage or overcurrent fault is latched and `ls_force` is 0. `ls_force` and `all_off` are never 1 together.
- R5: While enabled, with `uv_armed`=1 and `ss_active`=1, a synchronized undervoltage pulses `ss_restart` for the following cycle and latches nothing.
- R6: While `en`=0, a synchronized overvoltage sets a pre-enable clamp that drives `ls_force`. The clamp holds after the flag drops and clears on the first edge that samples `en`=1.
- R7: An overcurrent cycle asserts `ls_force` and `pwm_blank` for the following cycle, unless a shutdown fault is latched. A cycle without overcurrent resets the run count to zero. The seventh consecutive overcurrent cycle latches the overcurrent fault: `all_off`=1.
- R8: Every fault latch holds while `en` stays high and clears on any edge that samples `en`=0, or on reset.
- R9: `pgood` is registered. It is 1 only after an edge at which enable was high, `ss_active` was low, both synchronized window flags were low and no fault latch was set.
- R10: Under reset, `ls_force`=0, `all_off`=0, `pwm_blank`=1, `pgood`=0 and `ss_restart`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Asynchronous active-low supply reset |
| en | input | 1 | Converter enable |
| ss_active | input | 1 | Soft-start ramp in progress |
| uv_armed | input | 1 | Reference high enough for undervoltage checking |
| ov_flag | input | 1 | Output above the overvoltage threshold (asynchronous) |
| uv_flag | input | 1 | Output below the undervoltage threshold (asynchronous) |
| half_flag | input | 1 | Output below half the reference (asynchronous) |
| oc_flag | input | 1 | Inductor current above its limit (asynchronous) |
| ls_force | output | 1 | Force the low-side switch on |
| all_off | output | 1 | Turn both switches off |
| pwm_blank | output | 1 | Block high-side turn-on |
| pgood | output | 1 | Output within its window and no fault |
| ss_restart | output | 1 | Request to restart soft-start |

## Verification
Overvoltage clamping and overcurrent shutdown can occur in the same cycle. So can a latched undervoltage and a returning overvoltage. In both cases the low-side force must win over the all-off override. The random phase drives all four flags independently with a bias toward overcurrent runs and overvoltage pulses, so these overlaps occur often. Every cycle, all five outputs are compared against a bench model built from the requirements, including the rule that the two overrides never assert together.

// File: rtl/buck_prot_sup.sv
module buck_prot_sup #(
  parameter int OC_LIMIT = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ss_active,
  input  logic uv_armed,
  input  logic ov_flag,
  input  logic uv_flag,
  input  logic half_flag,
  input  logic oc_flag,
  output logic ls_force,
  output logic all_off,
  output logic pwm_blank,
  output logic pgood,
  output logic ss_restart
);
  localparam int CW = $clog2(OC_LIMIT + 1);

  logic [3:0] sync1, sync2;
  logic ov_s, uv_s, half_s, oc_s;
  logic en_q, ov_lat, uv_lat, oc_lat, ov_clamp, pre_clamp, oc_hold, pg_q, rq_q;
  logic [CW-1:0] oc_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {ov_flag, uv_flag, half_flag, oc_flag};
      sync2 <= sync1;
    end

  assign {ov_s, uv_s, half_s, oc_s} = sync2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q      <= 1'b0;
      ov_lat    <= 1'b0;
      uv_lat    <= 1'b0;
      oc_lat    <= 1'b0;
      ov_clamp  <= 1'b0;
      pre_clamp <= 1'b0;
      oc_hold   <= 1'b0;
      oc_cnt    <= '0;
      pg_q      <= 1'b0;
      rq_q      <= 1'b0;
    end else begin
      en_q    <= en;
      oc_hold <= en & oc_s;
      rq_q    <= en & uv_s & uv_armed & ss_active;
      pg_q    <= en & ~ss_active & ~ov_s & ~uv_s & ~ov_lat & ~uv_lat & ~oc_lat;
      if (!en) begin
        ov_lat    <= 1'b0;
        uv_lat    <= 1'b0;
        oc_lat    <= 1'b0;
        ov_clamp  <= 1'b0;
        oc_cnt    <= '0;
        pre_clamp <= pre_clamp | ov_s;
      end else begin
        pre_clamp <= 1'b0;
        if (ov_s) begin
          ov_lat   <= 1'b1;
          ov_clamp <= 1'b1;
        end else if (half_s) begin
          ov_clamp <= 1'b0;
        end
        if (uv_s && uv_armed && !ss_active)
          uv_lat <= 1'b1;
        if (!oc_s)
          oc_cnt <= '0;
        else if (oc_cnt != CW'(OC_LIMIT))
          oc_cnt <= oc_cnt + 1'b1;
        if (oc_s && oc_cnt == CW'(OC_LIMIT - 1))
          oc_lat <= 1'b1;
      end
    end

  assign ls_force   = ov_clamp | pre_clamp | (oc_hold & ~oc_lat & ~uv_lat);
  assign all_off    = (uv_lat | oc_lat) & ~ls_force;
  assign pwm_blank  = ~en_q | ov_lat | uv_lat | oc_lat | oc_hold | pre_clamp;
  assign pgood      = pg_q;
  assign ss_restart = rq_q;

  a_r2_ov_clamps: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ov_s) |=> ls_force);
  a_r4_overrides_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_force && all_off));
  a_r6_pre_clamp_drops: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> !pre_clamp);
  a_r8_uv_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && uv_lat) |=> uv_lat);
  a_r8_oc_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && oc_lat) |=> oc_lat);
  a_r9_pgood_low_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_lat || uv_lat || oc_lat) |=> !pgood);
  a_r7_latch_needs_oc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_lat) |-> $past(oc_s));
endmodule

// File: tb/buck_prot_sup_tb.sv
`timescale 1ns/1ps
module buck_prot_sup_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, ss_active = 0, uv_armed = 1;
  logic ov_flag = 0, uv_flag = 0, half_flag = 0, oc_flag = 0;
  logic ls_force, all_off, pwm_blank, pgood, ss_restart;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit run_model = 0;

  always #4 clk = ~clk;

  buck_prot_sup u_dut (.clk(clk), .rst_n(rst_n), .en(en), .ss_active(ss_active),
    .uv_armed(uv_armed), .ov_flag(ov_flag), .uv_flag(uv_flag), .half_flag(half_flag),
    .oc_flag(oc_flag), .ls_force(ls_force), .all_off(all_off), .pwm_blank(pwm_blank),
    .pgood(pgood), .ss_restart(ss_restart));

  // bench model of the requirements
  logic [3:0] m1, m2;
  logic m_en, m_ovl, m_uvl, m_ocl, m_ovc, m_pre, m_och, m_pg, m_rq;
  int m_cnt;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m1 <= 0; m2 <= 0; m_en <= 0; m_ovl <= 0; m_uvl <= 0; m_ocl <= 0;
      m_ovc <= 0; m_pre <= 0; m_och <= 0; m_pg <= 0; m_rq <= 0; m_cnt <= 0;
    end else begin
      m1 <= {ov_flag, uv_flag, half_flag, oc_flag};
      m2 <= m1;
      m_en <= en;
      m_och <= en & m2[0];
      m_rq <= en & m2[2] & uv_armed & ss_active;
      m_pg <= en & ~ss_active & ~m2[3] & ~m2[2] & ~m_ovl & ~m_uvl & ~m_ocl;
      m_pre <= en ? 1'b0 : (m_pre | m2[3]);
      m_ovl <= en & (m_ovl | m2[3]);
      m_ovc <= en & (m2[3] ? 1'b1 : (m2[1] ? 1'b0 : m_ovc));
      m_uvl <= en & (m_uvl | (m2[2] & uv_armed & ~ss_active));
      m_ocl <= en & (m_ocl | (m2[0] && m_cnt == 6));
      m_cnt <= (!en || !m2[0]) ? 0 : (m_cnt == 7 ? 7 : m_cnt + 1);
    end

  function automatic logic exp_ls();
    return m_ovc | m_pre | (m_och & ~m_ocl & ~m_uvl);
  endfunction
  function automatic logic exp_off();
    return (m_uvl | m_ocl) & ~exp_ls();
  endfunction
  function automatic logic exp_blank();
    return ~m_en | m_ovl | m_uvl | m_ocl | m_och | m_pre;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got %b expected %b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (run_model) begin
      chk("R2 ls_force model", ls_force, exp_ls());
      chk("R4 all_off model", all_off, exp_off());
      chk("R3 pwm_blank model", pwm_blank, exp_blank());
      chk("R9 pgood model", pgood, m_pg);
      chk("R5 ss_restart model", ss_restart, m_rq);
    end
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_en();
    en = 0; wait_cyc(1); en = 1; wait_cyc(3);
  endtask

  initial begin
    void'($urandom(32'd4711));
    wait_cyc(2);
    chk("R10 reset ls_force", ls_force, 0);
    chk("R10 reset all_off", all_off, 0);
    chk("R10 reset pwm_blank", pwm_blank, 1);
    chk("R10 reset pgood", pgood, 0);
    chk("R10 reset ss_restart", ss_restart, 0);
    rst_n = 1; run_model = 1;
    en = 1; wait_cyc(4);
    chk("R9 pgood up", pgood, 1);
    chk("R3 blank released", pwm_blank, 0);

    ov_flag = 1; wait_cyc(2);
    chk("R1 no effect after two edges", ls_force, 0);
    wait_cyc(1);
    chk("R1 effect at third edge", ls_force, 1);
    chk("R9 pgood drops on ov", pgood, 0);
    ov_flag = 0; wait_cyc(5);
    chk("R2 clamp held above half", ls_force, 1);
    half_flag = 1; wait_cyc(3);
    chk("R2 clamp released below half", ls_force, 0);
    chk("R3 blank while ov latched", pwm_blank, 1);
    half_flag = 0; ov_flag = 1; wait_cyc(3);
    chk("R2 clamp reasserts while latched", ls_force, 1);
    ov_flag = 0; half_flag = 1; wait_cyc(4);
    chk("R9 pgood low while latched", pgood, 0);
    half_flag = 0;
    toggle_en();
    chk("R8 en toggle clears ov latch", pwm_blank, 0);
    chk("R8 pgood back", pgood, 1);

    uv_flag = 1; wait_cyc(4);
    chk("R4 uv latches all_off", all_off, 1);
    uv_flag = 0; wait_cyc(4);
    chk("R4 uv latch holds", all_off, 1);
    chk("R8 uv latch holds with en high", pwm_blank, 1);
    toggle_en();
    chk("R8 uv latch cleared", all_off, 0);

    ss_active = 1; uv_flag = 1; wait_cyc(3);
    chk("R5 restart request", ss_restart, 1);
    chk("R5 no latch in soft-start", all_off, 0);
    uv_flag = 0; wait_cyc(3);
    chk("R5 restart ends", ss_restart, 0);
    ss_active = 0; wait_cyc(3);
    chk("R5 nothing latched", pwm_blank, 0);

    en = 0; ov_flag = 1; wait_cyc(4);
    chk("R6 pre-enable clamp", ls_force, 1);
    ov_flag = 0; wait_cyc(4);
    chk("R6 pre-enable clamp holds", ls_force, 1);
    en = 1; wait_cyc(1);
    chk("R6 clamp cleared by enable", ls_force, 0);
    wait_cyc(3);

    oc_flag = 1; wait_cyc(3);
    chk("R7 oc forces low side", ls_force, 1);
    chk("R7 oc blanks pwm", pwm_blank, 1);
    wait_cyc(3); oc_flag = 0; wait_cyc(5);
    chk("R7 six cycles do not latch", all_off, 0);
    oc_flag = 1; wait_cyc(4); oc_flag = 0; wait_cyc(1); oc_flag = 1; wait_cyc(4);
    oc_flag = 0; wait_cyc(5);
    chk("R7 gap resets run", all_off, 0);
    oc_flag = 1; wait_cyc(7); oc_flag = 0; wait_cyc(5);
    chk("R7 seven cycles latch", all_off, 1);
    toggle_en();
    chk("R8 oc latch cleared", all_off, 0);

    for (int i = 0; i < 4000; i++) begin
      ov_flag   = ($urandom % 16) == 0;
      uv_flag   = ($urandom % 20) == 0;
      half_flag = ($urandom % 3) == 0;
      if (($urandom % 8) == 0) oc_flag = ~oc_flag;
      if (($urandom % 200) == 0) ss_active = ~ss_active;
      uv_armed  = ($urandom % 10) != 0;
      en        = ($urandom % 150) != 0;
      wait_cyc(1);
    end
    wait_cyc(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule